// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host-facing register file of a PC-style parallel port. A host reaches it through a simple synchronous strobe bus with a size qualifier. The block decodes a window of eight byte offsets at a configurable base address. It drives the peripheral data lines, four control lines and a data-line output enable. It presents the peripheral status lines on a status read. It also turns host accesses to two offsets into single address or data strobes of the enhanced (EPP-style) protocol.

A falling edge on the peripheral's acknowledge line is synchronized and edge-detected. If the interrupt-on-acknowledge control bit is set, this edge raises a level interrupt on one configurable line of an interrupt vector. Any status read drops that interrupt. The data-direction bit of a control write steers the data lines between driving and sampling. It is removed from the stored control value, and the two reserved control bits always read back as one.

Top module: `lpt_host_regs`

## Requirements
- R1: An access is taken only when `bus_sel` is high and bits [ADDR_W-1:3] of `bus_addr` equal those of `BASE_ADDR` (default 0x378). Bits [2:0] select the offset: 0 data, 1 status, 2 control, 3 EPP address, 4 EPP data. A read outside the window gives no response. A read inside it gives `rd_valid` one cycle after the strobe, or two cycles after it for offsets 3 and 4.
- R2: A byte access has `bus_size` = 0. A read of any other size returns `rd_unused` = 1 with `rd_data` = 0xFF. A write of any other size changes nothing.
- R3: A byte write to offset 0 stores the byte. In forward direction, `pd_out` shows it with `pd_oe` = 1, and a data read returns it.
- R4: On a control write, the byte has bits 7 and 6 forced to one. Bit 5 sets the direction: 1 is reverse (`pd_oe` = 0) and 0 is forward. Bit 5 is then cleared before storing. `ctrl_lines` shows stored bits [3:0] (bit0 strobe, bit1 auto linefeed, bit2 reset, bit3 select). A control read returns the stored value with bits 7 and 6 set and bit 5 clear.
- R5: A control write whose forced value equals the stored control value changes nothing. This includes the direction, so writing an equal value with bit 5 clear leaves reverse direction in place.
- R6: In reverse direction, a data read returns `pd_in` as sampled at the strobe edge.
- R7: A status read returns {`st_lines`[4:0], interrupt flag, 1, `epp_tmo`}. The `st_lines` field takes bits 7..3 (busy, ack, paper out, select, error). The interrupt flag is bit 2 and shows its value before the read. Bit 1 is the constant 1 and bit 0 is `epp_tmo`.
- R8: A falling edge of `ack_n` sets the interrupt only while control bit 4 is set. The interrupt appears on `irq_lines`[IRQ_LINE] (default 7) within four cycles. All other lines stay 0. An acknowledge held low counts once.
- R9: Any status read clears the interrupt.
- R10: A byte write to offset 3 (or 4) gives, in the next cycle, one cycle of `epp_astb` (or `epp_dstb`) with `epp_wr` = 1, `pd_out` = the byte and `pd_oe` = 1.
- R11: A read of offset 3 (or 4) gives, in the next cycle, one cycle of `epp_astb` (or `epp_dstb`) with `epp_wr` = 0 and `pd_oe` = 0. The value of `pd_in` during that cycle is returned.
- R12: Writes to offsets 5 to 7 change no output. Reads of them return 0xFF with `rd_unused` = 0.
- R13: After reset, the data register is 0 and the stored control value is 0xC0. The direction is forward, the interrupt is low and no read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_size | input | SIZE_W | Access size, 0 means one byte |
| bus_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response strobe |
| rd_unused | output | 1 | Read was not byte-sized |
| rd_data | output | 8 | Read byte |
| pd_out | output | 8 | Data lines, outgoing |
| pd_in | input | 8 | Data lines, incoming |
| pd_oe | output | 1 | Data line output enable |
| ctrl_lines | output | 4 | Strobe, auto linefeed, reset, select |
| st_lines | input | 5 | Busy, ack, paper out, select, error (bit4..bit0) |
| epp_tmo | input | 1 | EPP timeout flag |
| ack_n | input | 1 | Asynchronous acknowledge, active low |
| epp_astb | output | 1 | EPP address strobe |
| epp_dstb | output | 1 | EPP data strobe |
| epp_wr | output | 1 | EPP cycle direction, 1 write |
| irq_lines | output | NUM_IRQ | Interrupt vector |

## Verification
The checker assumes the host issues one access at a time. It assumes `bus_sel` lasts a single cycle and the next strobe comes only after the previous response and any EPP strobe have ended. Under that rule, an EPP strobe never lasts two cycles and every response can be traced to a read one or two cycles earlier. The bench spaces every access by at least two cycles and waits for each response before moving on. It drives `ack_n` only in directed phases, and it holds `pd_in` steady across each read, EPP read cycles included.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_STAT = 3'd1,
        OFS_CTRL = 3'd2,
        OFS_EADR = 3'd3,
        OFS_EDAT = 3'd4,
        OFS_RSV5 = 3'd5,
        OFS_RSV6 = 3'd6,
        OFS_RSV7 = 3'd7
    } lpt_ofs_e;

    localparam int                CTRL_DIR_BIT   = 5;
    localparam int                CTRL_IRQEN_BIT = 4;
    localparam logic [BYTE_W-1:0] CTRL_FORCE1    = 8'hC0;
    localparam logic [BYTE_W-1:0] CTRL_DIR_MASK  = 8'h20;
    localparam logic [BYTE_W-1:0] UNUSED_BYTE    = 8'hFF;

endpackage

// File: rtl/lpt_ack_sync.sv
module lpt_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic ack_fall
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = ack_n;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], ack_n};
        end
    endgenerate

    always_comb last_d = sync_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign ack_fall = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/lpt_epp_cycle.sv
module lpt_epp_cycle
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_addr,
    input  logic              go_data,
    input  logic              go_wr,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [BYTE_W-1:0] pins_in,
    output logic              astb,
    output logic              dstb,
    output logic              cyc_wr,
    output logic [BYTE_W-1:0] cyc_byte,
    output logic              rd_done,
    output logic [BYTE_W-1:0] rd_byte
);
    typedef struct packed {
        logic              astb;
        logic              dstb;
        logic              wr;
        logic [BYTE_W-1:0] wbyte;
        logic              done;
        logic [BYTE_W-1:0] rbyte;
    } epp_t;

    epp_t st_d, st_q;
    logic busy;

    assign busy = st_q.astb | st_q.dstb;

    always_comb begin
        st_d       = st_q;
        st_d.astb  = go_addr;
        st_d.dstb  = go_data;
        st_d.wr    = (go_addr | go_data) ? go_wr : st_q.wr;
        st_d.wbyte = (go_addr | go_data) && go_wr ? wbyte : st_q.wbyte;
        st_d.done  = busy & ~st_q.wr;
        st_d.rbyte = (busy & ~st_q.wr) ? pins_in : st_q.rbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign astb     = st_q.astb;
    assign dstb     = st_q.dstb;
    assign cyc_wr   = st_q.wr;
    assign cyc_byte = st_q.wbyte;
    assign rd_done  = st_q.done;
    assign rd_byte  = st_q.rbyte;

endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
    import lpt_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                SIZE_W      = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h378,
    parameter int                NUM_IRQ     = 16,
    parameter int                IRQ_LINE    = 7,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [SIZE_W-1:0]  bus_size,
    input  logic [7:0]         bus_wdata,
    output logic               rd_valid,
    output logic               rd_unused,
    output logic [7:0]         rd_data,
    output logic [7:0]         pd_out,
    input  logic [7:0]         pd_in,
    output logic               pd_oe,
    output logic [3:0]         ctrl_lines,
    input  logic [4:0]         st_lines,
    input  logic               epp_tmo,
    input  logic               ack_n,
    output logic               epp_astb,
    output logic               epp_dstb,
    output logic               epp_wr,
    output logic [NUM_IRQ-1:0] irq_lines
);
    localparam int OFS_W = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] ctrl;
        logic              rev;
        logic              irq;
        logic              rd_valid;
        logic              rd_unused;
        logic [BYTE_W-1:0] rd_data;
    } regs_t;

    regs_t r_d, r_q;

    logic              hit, byte_acc, wr_ok, rd_req, stat_rd;
    logic              go_a, go_d, ack_fall;
    logic              epp_rd_done, epp_cyc_wr;
    logic [BYTE_W-1:0] epp_rd_byte, epp_byte, ctrl_new;
    lpt_ofs_e          ofs;
    logic              irq_now, irq_en_now;

    assign hit      = bus_sel && (bus_addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
    assign ofs      = lpt_ofs_e'(bus_addr[OFS_W-1:0]);
    assign byte_acc = (bus_size == '0);
    assign wr_ok    = hit & bus_wr & byte_acc;
    assign rd_req   = hit & ~bus_wr;
    assign stat_rd  = rd_req & byte_acc & (ofs == OFS_STAT);
    assign ctrl_new = bus_wdata | CTRL_FORCE1;

    lpt_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (ack_n),
        .ack_fall (ack_fall)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rd_valid  = 1'b0;
        r_d.rd_unused = 1'b0;
        go_a          = 1'b0;
        go_d          = 1'b0;

        if (wr_ok) begin
            case (ofs)
                OFS_DATA: r_d.data = bus_wdata;
                OFS_CTRL: begin
                    if (ctrl_new != r_q.ctrl) begin
                        r_d.rev  = ctrl_new[CTRL_DIR_BIT];
                        r_d.ctrl = ctrl_new & ~CTRL_DIR_MASK;
                    end
                end
                OFS_EADR: go_a = 1'b1;
                OFS_EDAT: go_d = 1'b1;
                default:  ;
            endcase
        end

        if (rd_req) begin
            if (!byte_acc) begin
                r_d.rd_valid  = 1'b1;
                r_d.rd_unused = 1'b1;
                r_d.rd_data   = UNUSED_BYTE;
            end else begin
                case (ofs)
                    OFS_DATA: begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = r_q.rev ? pd_in : r_q.data;
                    end
                    OFS_STAT: begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = {st_lines, r_q.irq, 1'b1, epp_tmo};
                    end
                    OFS_CTRL: begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = r_q.ctrl | CTRL_FORCE1;
                    end
                    OFS_EADR: go_a = 1'b1;
                    OFS_EDAT: go_d = 1'b1;
                    default: begin
                        r_d.rd_valid = 1'b1;
                        r_d.rd_data  = UNUSED_BYTE;
                    end
                endcase
            end
        end

        if (stat_rd) r_d.irq = 1'b0;
        if (ack_fall && r_q.ctrl[CTRL_IRQEN_BIT]) r_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ctrl <= CTRL_FORCE1;
        end else begin
            r_q <= r_d;
        end
    end

    lpt_epp_cycle u_epp (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_addr  (go_a),
        .go_data  (go_d),
        .go_wr    (bus_wr),
        .wbyte    (bus_wdata),
        .pins_in  (pd_in),
        .astb     (epp_astb),
        .dstb     (epp_dstb),
        .cyc_wr   (epp_cyc_wr),
        .cyc_byte (epp_byte),
        .rd_done  (epp_rd_done),
        .rd_byte  (epp_rd_byte)
    );

    assign epp_wr     = epp_cyc_wr;
    assign pd_out     = ((epp_astb | epp_dstb) && epp_cyc_wr) ? epp_byte : r_q.data;
    assign pd_oe      = (epp_astb | epp_dstb) ? epp_cyc_wr : ~r_q.rev;
    assign ctrl_lines = r_q.ctrl[3:0];
    assign rd_valid   = r_q.rd_valid | epp_rd_done;
    assign rd_unused  = r_q.rd_unused;
    assign rd_data    = epp_rd_done ? epp_rd_byte : r_q.rd_data;
    assign irq_now    = r_q.irq;
    assign irq_en_now = r_q.ctrl[CTRL_IRQEN_BIT];

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
            if (i == IRQ_LINE) begin : g_on
                assign irq_lines[i] = r_q.irq;
            end else begin : g_off
                assign irq_lines[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/lpt_host_regs_chk.sv
module lpt_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_req,
    input logic       stat_rd,
    input logic       irq,
    input logic       irq_en,
    input logic       rd_valid,
    input logic       rd_unused,
    input logic [7:0] rd_data,
    input logic       epp_astb,
    input logic       epp_dstb,
    input logic       epp_wr,
    input logic       pd_oe
);
    // R8: the interrupt only rises while the enable bit was set
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));

    // R9: the interrupt only drops after a status read
    a_r9_irq_drop_on_status: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_rd));

    // R2: an unused-size response carries all ones
    a_r2_unused_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_unused) |-> (rd_data == 8'hFF));

    // R1: every response traces back to a read one or two cycles earlier
    a_r1_response_has_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_req) || $past(rd_req, 2)));

    // R10: address and data strobes never overlap
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(epp_astb && epp_dstb));

    // R10: an EPP strobe lasts one cycle
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (epp_astb || epp_dstb) |=> !(epp_astb || epp_dstb));

    // R11: an EPP read cycle releases the data lines
    a_r11_read_releases_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ((epp_astb || epp_dstb) && !epp_wr) |-> !pd_oe);
endmodule

bind lpt_host_regs lpt_host_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .stat_rd   (stat_rd),
    .irq       (irq_now),
    .irq_en    (irq_en_now),
    .rd_valid  (rd_valid),
    .rd_unused (rd_unused),
    .rd_data   (rd_data),
    .epp_astb  (epp_astb),
    .epp_dstb  (epp_dstb),
    .epp_wr    (epp_wr),
    .pd_oe     (pd_oe)
);

// File: tb/tb_lpt_host_regs.sv
module tb_lpt_host_regs;
    localparam logic [15:0] BASE = 16'h0378;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [7:0]  bus_wdata = '0;
    logic        rd_valid, rd_unused, pd_oe, epp_astb, epp_dstb, epp_wr;
    logic [7:0]  rd_data, pd_out;
    logic [7:0]  pd_in = '0;
    logic [3:0]  ctrl_lines;
    logic [4:0]  st_lines = '0;
    logic        epp_tmo = 1'b0;
    logic        ack_n = 1'b1;
    logic [15:0] irq_lines;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] m_data, m_ctrl;
    logic       m_rev, m_irq;

    always #2.5 clk = ~clk;

    lpt_host_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_unused(rd_unused), .rd_data(rd_data),
        .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .ctrl_lines(ctrl_lines),
        .st_lines(st_lines), .epp_tmo(epp_tmo), .ack_n(ack_n),
        .epp_astb(epp_astb), .epp_dstb(epp_dstb), .epp_wr(epp_wr),
        .irq_lines(irq_lines)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_status(input logic [4:0] st, input logic irq, input logic tmo);
        return {st, irq, 1'b1, tmo};
    endfunction

    // model of a byte control write
    task automatic m_ctrl_write(input logic [7:0] d);
        logic [7:0] v;
        v = d | 8'hC0;
        if (v != m_ctrl) begin
            m_rev  = v[5];
            m_ctrl = v & 8'hDF;
        end
    endtask

    // returns at the negedge after the strobe edge
    task automatic do_write(input logic [15:0] a, input logic [1:0] sz, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] sz,
                           output logic got, output logic [7:0] d, output logic unused,
                           output logic rd_pulse);
        int n;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_sel = 1'b0;
        rd_pulse = (epp_astb | epp_dstb) & ~epp_wr & ~pd_oe;
        n = 0;
        while (!rd_valid && n < 4) begin
            @(negedge clk);
            n++;
        end
        got = rd_valid; d = rd_data; unused = rd_unused;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        logic got, un, pl;
        logic [7:0] d;
        void'($urandom(32'd1234));
        m_data = 8'h00; m_ctrl = 8'hC0; m_rev = 1'b0; m_irq = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk("R13 pd_out", pd_out, 8'h00);
        chk("R13 pd_oe", pd_oe, 1'b1);
        chk("R13 ctrl_lines", ctrl_lines, 4'h0);
        chk("R13 irq", irq_lines, 16'h0);
        chk("R13 rd_valid", rd_valid, 1'b0);
        do_read(BASE | 16'd2, 2'd0, got, d, un, pl);
        chk("R13 ctrl read", d, 8'hC0);
        do_read(BASE | 16'd0, 2'd0, got, d, un, pl);
        chk("R13 data read", d, 8'h00);

        // R1 out of window
        do_read(16'h0278, 2'd0, got, d, un, pl);
        chk("R1 no response outside window", got, 1'b0);
        do_write(16'h0270, 2'd0, 8'h5A);
        chk("R1 outside write ignored", pd_out, 8'h00);

        // R3 data write/read
        do_write(BASE, 2'd0, 8'hA5);
        m_data = 8'hA5;
        chk("R3 pd_out", pd_out, 8'hA5);
        do_read(BASE, 2'd0, got, d, un, pl);
        chk("R3 data read", d, 8'hA5);

        // R2 wide accesses
        do_write(BASE, 2'd1, 8'h11);
        chk("R2 wide write dropped", pd_out, 8'hA5);
        do_read(BASE | 16'd2, 2'd2, got, d, un, pl);
        chk("R2 wide read unused", {got, un, d}, {2'b11, 8'hFF});

        // R4/R5/R6 direction control
        do_write(BASE | 16'd2, 2'd0, 8'h24);
        m_ctrl_write(8'h24);
        chk("R4 reverse pd_oe", pd_oe, 1'b0);
        chk("R4 ctrl_lines", ctrl_lines, 4'h4);
        do_read(BASE | 16'd2, 2'd0, got, d, un, pl);
        chk("R4 ctrl read", d, 8'hC4);
        pd_in = 8'h3C;
        do_read(BASE, 2'd0, got, d, un, pl);
        chk("R6 reverse data read", d, 8'h3C);
        do_write(BASE | 16'd2, 2'd0, 8'h04);
        m_ctrl_write(8'h04);
        chk("R5 equal write keeps reverse", pd_oe, 1'b0);
        do_write(BASE | 16'd2, 2'd0, 8'h05);
        m_ctrl_write(8'h05);
        chk("R4 forward again", pd_oe, 1'b1);
        chk("R4 ctrl_lines strobe", ctrl_lines, 4'h5);

        // R10 EPP writes
        do_write(BASE | 16'd3, 2'd0, 8'h77);
        chk("R10 addr strobe", {epp_astb, epp_dstb, epp_wr, pd_oe}, 4'b1011);
        chk("R10 addr byte", pd_out, 8'h77);
        @(negedge clk);
        chk("R10 strobe ends", {epp_astb, pd_out}, {1'b0, m_data});
        do_write(BASE | 16'd4, 2'd0, 8'h88);
        chk("R10 data strobe", {epp_astb, epp_dstb, epp_wr, pd_oe}, 4'b0111);
        chk("R10 data byte", pd_out, 8'h88);

        // R11 EPP reads
        pd_in = 8'hC3;
        do_read(BASE | 16'd3, 2'd0, got, d, un, pl);
        chk("R11 addr read cycle", {got, pl, d}, {2'b11, 8'hC3});
        pd_in = 8'h1E;
        do_read(BASE | 16'd4, 2'd0, got, d, un, pl);
        chk("R11 data read cycle", {got, pl, d}, {2'b11, 8'h1E});

        // R12 reserved offsets
        for (int k = 5; k < 8; k++) begin
            do_write(BASE | 16'(k), 2'd0, 8'h00);
            chk("R12 write ignored", {pd_out, pd_oe, ctrl_lines, epp_astb, epp_dstb},
                {m_data, ~m_rev, m_ctrl[3:0], 2'b00});
            do_read(BASE | 16'(k), 2'd0, got, d, un, pl);
            chk("R12 read all ones", {got, un, d}, {2'b10, 8'hFF});
        end

        // R7/R8/R9 interrupt
        do_write(BASE | 16'd2, 2'd0, 8'h10);
        m_ctrl_write(8'h10);
        ack_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 irq raised on line", irq_lines, 16'h0080);
        repeat (6) @(negedge clk);
        chk("R8 irq held", irq_lines, 16'h0080);
        st_lines = 5'b10110; epp_tmo = 1'b1;
        do_read(BASE | 16'd1, 2'd0, got, d, un, pl);
        chk("R7 status read", d, f_status(5'b10110, 1'b1, 1'b1));
        chk("R9 irq cleared", irq_lines, 16'h0);
        repeat (6) @(negedge clk);
        chk("R8 held ack counts once", irq_lines, 16'h0);
        ack_n = 1'b1;
        repeat (4) @(negedge clk);
        do_write(BASE | 16'd2, 2'd0, 8'h00);
        m_ctrl_write(8'h00);
        ack_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 disabled no irq", irq_lines, 16'h0);
        ack_n = 1'b1;
        repeat (4) @(negedge clk);
        do_write(BASE | 16'd2, 2'd0, 8'h10);
        m_ctrl_write(8'h10);
        @(negedge clk); ack_n = 1'b0;
        @(negedge clk); ack_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 short pulse", irq_lines, 16'h0080);
        do_read(BASE | 16'd1, 2'd0, got, d, un, pl);
        chk("R9 cleared again", irq_lines, 16'h0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] o;
            logic       w;
            logic [1:0] sz;
            logic [7:0] v;
            o  = 3'($urandom % 8);
            w  = 1'($urandom % 2);
            sz = ($urandom % 5 == 0) ? 2'(1 + $urandom % 2) : 2'd0;
            v  = 8'($urandom);
            pd_in = 8'($urandom); st_lines = 5'($urandom); epp_tmo = 1'($urandom);
            if (w) begin
                do_write(BASE | 16'(o), sz, v);
                if (sz == 0 && o == 0) m_data = v;
                if (sz == 0 && o == 2) m_ctrl_write(v);
                if (sz == 0 && (o == 3 || o == 4)) begin
                    chk("R10 random strobe", {epp_astb, epp_dstb, epp_wr, pd_out},
                        {(o == 3), (o == 4), 1'b1, v});
                    @(negedge clk);
                end
                chk("R3 random lines", {pd_out, pd_oe}, {m_data, ~m_rev});
                chk("R4 random ctrl", ctrl_lines, m_ctrl[3:0]);
            end else begin
                logic [7:0] e;
                do_read(BASE | 16'(o), sz, got, d, un, pl);
                if (sz != 0) chk("R2 random unused", {got, un, d}, {2'b11, 8'hFF});
                else begin
                    case (o)
                        3'd0: e = m_rev ? pd_in : m_data;
                        3'd1: e = f_status(st_lines, m_irq, epp_tmo);
                        3'd2: e = m_ctrl | 8'hC0;
                        3'd3, 3'd4: e = pd_in;
                        default: e = 8'hFF;
                    endcase
                    chk("R1 random read", {got, un, d}, {2'b10, e});
                end
            end
        end

        done = 1;
        finish_up();
    end
endmodule